// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when a DRAM controller has to refresh the memory. It sends each refresh to the command scheduler as a request. A free-running interval timer produces one refresh for every programmed period. Software can add a single refresh at any moment with a one-cycle pulse. A control bit turns the timer off, and software pulses still work while it is off. In per-bank mode, which low-power DRAM parts use, each timer tick refreshes one bank instead of all banks. The timer period is then divided by the bank count, and a bank pointer steps through the banks in turn.

Refreshes that are not granted wait in a pending counter. The counter saturates, so a stalled scheduler cannot make it wrap. The request output is a valid/ready stream. `ref_valid` stays high while the counter is nonzero, and each cycle with both `ref_valid` and `ref_ready` high grants one refresh. Back-pressure does no harm: the consumer may hold `ref_ready` low as long as it wants and refreshes only pile up, up to the limit. There is one exception to the rule that valid stays high until granted. Raising `hold` (for example during self-refresh) withdraws `ref_valid` and freezes both the timer and the counter. No request is lost, because the counter keeps its value.

Top module: `dram_refresh_scheduler`

## Requirements
- R1: After reset, `ref_valid` is 0 and `ref_bank` is 0, and no refresh is pending.
- R2: With the timer enabled in all-bank mode, one refresh is added for every `max(interval,1)` cycles the timer is enabled. A consumer that always grants therefore sees exactly `interval` cycles between grants.
- R3: While `auto_off` is 1 the timer adds no refresh and its phase is cleared.
- R4: A one-cycle `sw_refresh` pulse adds exactly one refresh, also while `auto_off` is 1.
- R5: In per-bank mode the timer period is `max(interval >> log2(BANKS), 1)` cycles and `ref_per_bank` is 1. In all-bank mode `ref_per_bank` is 0.
- R6: In per-bank mode `ref_bank` starts at 0 after reset and steps to (bank+1) mod BANKS after each granted per-bank refresh. In all-bank mode `ref_bank` reads 0 and the pointer keeps its value.
- R7: The pending count saturates at PEND_MAX (8). Once saturated, exactly 8 grants follow.
- R8: While refreshes are pending and `hold` is 0, `ref_valid` stays 1 until it is granted. `ref_bank` does not change while the request waits.
- R9: While `hold` is 1, `ref_valid` is 0, the timer does not advance, the pending count does not change, and a `sw_refresh` pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval | input | TIMER_W | Average all-bank refresh period in cycles |
| auto_off | input | 1 | 1 disables timer-generated refreshes |
| per_bank_en | input | 1 | 1 selects per-bank refresh mode |
| sw_refresh | input | 1 | One-cycle pulse requesting one refresh |
| hold | input | 1 | Freezes timer and pending count, withdraws request |
| ref_valid | output | 1 | A refresh is offered |
| ref_ready | input | 1 | Scheduler grants the offered refresh |
| ref_bank | output | BANK_W | Target bank (0 in all-bank mode) |
| ref_per_bank | output | 1 | 1 for a per-bank refresh, 0 for all-bank |

## Verification
The first pattern is a consumer that always grants. It measures the time between grants and so separates the all-bank period from the divided per-bank period. The second pattern keeps `ref_ready` low for a long time, so the pending count hits its ceiling; the bench then counts the grants, which shows whether the count saturates or wraps. Software pulses are given with the timer off, and a second pulse is given during `hold`, to tell accepted pulses from dropped ones. A `hold` window placed between two timer grants shows whether the timer phase is frozen or restarted.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic {
    KIND_ALL  = 1'b0,
    KIND_BANK = 1'b1
  } ref_kind_e;

  function automatic int unsigned clog2_min1(int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int TIMER_W = 16,
  parameter int SHIFT   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] interval,
  input  logic               per_bank_en,
  input  logic               auto_off,
  input  logic               hold,
  output logic               tick
);
  logic [TIMER_W-1:0] cnt_q;
  logic [TIMER_W-1:0] raw_period;
  logic [TIMER_W-1:0] period;
  logic               run;
  logic               at_end;

  always_comb begin
    raw_period = per_bank_en ? (interval >> SHIFT) : interval;
    period     = (raw_period == '0) ? TIMER_W'(1) : raw_period;
  end

  assign run    = !auto_off && !hold;
  assign at_end = (cnt_q >= period - TIMER_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || auto_off) begin
      cnt_q <= '0;
    end else if (run) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_q + TIMER_W'(1);
    end
  end
endmodule

// File: rtl/refsched_pending.sv
module refsched_pending #(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic sw_refresh,
  input  logic grant,
  output logic nonzero
);
  localparam int SUM_W = PEND_W + 2;

  logic [PEND_W-1:0] pend_q;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum = SUM_W'(pend_q) + SUM_W'(tick) + SUM_W'(sw_refresh) - SUM_W'(grant);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (!hold) begin
      if (sum > SUM_W'(PEND_MAX)) pend_q <= PEND_W'(PEND_MAX);
      else                        pend_q <= sum[PEND_W-1:0];
    end
  end

  assign nonzero = (pend_q != '0);
endmodule

// File: rtl/refsched_bank_step.sv
module refsched_bank_step #(
  parameter int BANKS  = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_bank_en,
  input  logic              grant,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (grant && per_bank_en) begin
      if (ptr_q == BANK_W'(BANKS - 1)) ptr_q <= '0;
      else                             ptr_q <= ptr_q + BANK_W'(1);
    end
  end

  assign bank = per_bank_en ? ptr_q : '0;
endmodule

// File: rtl/dram_refresh_scheduler.sv
module dram_refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int TIMER_W  = 16,
  parameter int BANKS    = 8,
  parameter int PEND_MAX = 8,
  localparam int BANK_W  = clog2_min1(BANKS),
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] interval,
  input  logic               auto_off,
  input  logic               per_bank_en,
  input  logic               sw_refresh,
  input  logic               hold,
  output logic               ref_valid,
  input  logic               ref_ready,
  output logic [BANK_W-1:0]  ref_bank,
  output logic               ref_per_bank
);
  localparam int SHIFT = $clog2(BANKS);

  logic      tick;
  logic      pending;
  logic      grant;
  ref_kind_e kind;

  assign grant = ref_valid && ref_ready;

  refsched_timer #(.TIMER_W(TIMER_W), .SHIFT(SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .interval(interval), .per_bank_en(per_bank_en),
    .auto_off(auto_off), .hold(hold), .tick(tick)
  );

  refsched_pending #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick),
    .sw_refresh(sw_refresh), .grant(grant), .nonzero(pending)
  );

  refsched_bank_step #(.BANKS(BANKS), .BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .per_bank_en(per_bank_en), .grant(grant),
    .bank(ref_bank)
  );

  assign kind         = per_bank_en ? KIND_BANK : KIND_ALL;
  assign ref_per_bank = (kind == KIND_BANK);
  assign ref_valid    = pending && !hold;
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_off,
  input logic              per_bank_en,
  input logic              sw_refresh,
  input logic              hold,
  input logic              ref_valid,
  input logic              ref_ready,
  input logic [BANK_W-1:0] ref_bank
);
  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready) |=> (ref_valid || hold));

  // R8
  bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready) |=>
      (ref_bank == $past(ref_bank) || per_bank_en != $past(per_bank_en)));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !ref_valid);

  // R6
  bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && per_bank_en) |=>
      (!per_bank_en || ref_bank != $past(ref_bank)));

  // R3
  no_spont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_off && !sw_refresh && !ref_valid && !hold) |=> (!ref_valid || hold != $past(hold)));
endmodule

bind dram_refresh_scheduler refsched_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_off(auto_off), .per_bank_en(per_bank_en),
  .sw_refresh(sw_refresh), .hold(hold), .ref_valid(ref_valid),
  .ref_ready(ref_ready), .ref_bank(ref_bank)
);

// File: tb/sim_dram_refresh_scheduler.sv
`timescale 1ns/1ps
module sim_dram_refresh_scheduler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] interval = 16'd2;
  logic        auto_off = 1'b1;
  logic        per_bank_en = 1'b0;
  logic        sw_refresh = 1'b0;
  logic        hold = 1'b0;
  logic        ref_valid;
  logic        ref_ready = 1'b0;
  logic [2:0]  ref_bank;
  logic        ref_per_bank;

  typedef struct { int bank; bit pb; } exp_t;
  exp_t exp_q[$];
  int   gtimes[$];
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_scheduler u0 (
    .clk(clk), .rst_n(rst_n), .interval(interval), .auto_off(auto_off),
    .per_bank_en(per_bank_en), .sw_refresh(sw_refresh), .hold(hold),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_bank(ref_bank),
    .ref_per_bank(ref_per_bank)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int bank, input bit pb);
    exp_t e;
    e.bank = bank;
    e.pb   = pb;
    exp_q.push_back(e);
  endtask

  task automatic sw_pulse();
    sw_refresh = 1'b1;
    step(1);
    sw_refresh = 1'b0;
  endtask

  // monitor: a handshake seen at negedge completes at the next posedge
  always @(negedge clk) begin
    if (rst_n && ref_valid && ref_ready) begin
      gtimes.push_back(cyc);
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected grant", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ref_bank == e.bank[2:0], "R6 bank", int'(ref_bank), e.bank);
        chk(ref_per_bank == e.pb, "R5 kind", int'(ref_per_bank), int'(e.pb));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(ref_valid == 1'b0, "R1 valid", int'(ref_valid), 0);
    chk(ref_bank == 3'd0, "R1 bank", int'(ref_bank), 0);

    // R3 timer off: nothing appears
    step(50);
    chk(ref_valid == 1'b0, "R3 auto_off quiet", int'(ref_valid), 0);

    // R4 software pulse while auto off, R8 held under back-pressure
    sw_pulse();
    step(2);
    chk(ref_valid == 1'b1, "R4 sw valid", int'(ref_valid), 1);
    step(6);
    chk(ref_valid == 1'b1, "R8 valid held", int'(ref_valid), 1);
    gtimes.delete();
    push(0, 0);
    ref_ready = 1'b1;
    step(10);
    ref_ready = 1'b0;
    chk(gtimes.size() == 1, "R4 one grant", gtimes.size(), 1);
    chk(ref_valid == 1'b0, "R4 drained", int'(ref_valid), 0);

    // R2 all-bank period 20
    gtimes.delete();
    interval = 16'd20;
    ref_ready = 1'b1;
    auto_off = 1'b0;
    repeat (3) push(0, 0);
    step(70);
    auto_off = 1'b1;
    step(2);
    chk(gtimes.size() == 3, "R2 grant count", gtimes.size(), 3);
    if (gtimes.size() == 3) begin
      chk(gtimes[1] - gtimes[0] == 20, "R2 spacing", gtimes[1] - gtimes[0], 20);
      chk(gtimes[2] - gtimes[1] == 20, "R2 spacing", gtimes[2] - gtimes[1], 20);
    end

    // R7 saturation
    ref_ready = 1'b0;
    interval = 16'd4;
    auto_off = 1'b0;
    step(100);
    auto_off = 1'b1;
    gtimes.delete();
    repeat (8) push(0, 0);
    ref_ready = 1'b1;
    step(20);
    chk(gtimes.size() == 8, "R7 saturated grants", gtimes.size(), 8);
    chk(ref_valid == 1'b0, "R7 empty", int'(ref_valid), 0);

    // R9 hold freezes count and drops sw pulse
    ref_ready = 1'b0;
    sw_pulse();
    sw_pulse();
    hold = 1'b1;
    step(2);
    chk(ref_valid == 1'b0, "R9 valid low in hold", int'(ref_valid), 0);
    sw_pulse();
    step(3);
    hold = 1'b0;
    gtimes.delete();
    push(0, 0);
    push(0, 0);
    ref_ready = 1'b1;
    step(10);
    chk(gtimes.size() == 2, "R9 frozen count", gtimes.size(), 2);

    // R9 hold freezes timer phase
    gtimes.delete();
    interval = 16'd30;
    auto_off = 1'b0;
    push(0, 0);
    push(0, 0);
    step(35);
    step(10);
    hold = 1'b1;
    step(50);
    hold = 1'b0;
    step(40);
    auto_off = 1'b1;
    step(2);
    chk(gtimes.size() == 2, "R9 timer grants", gtimes.size(), 2);
    if (gtimes.size() == 2)
      chk(gtimes[1] - gtimes[0] == 80, "R9 timer frozen", gtimes[1] - gtimes[0], 80);

    // R5 R6 per-bank round robin, period 64>>3 = 8
    gtimes.delete();
    interval = 16'd64;
    per_bank_en = 1'b1;
    auto_off = 1'b0;
    for (int b = 0; b < 9; b++) push(b % 8, 1);
    step(76);
    auto_off = 1'b1;
    step(2);
    chk(gtimes.size() == 9, "R5 per-bank grants", gtimes.size(), 9);
    if (gtimes.size() == 9)
      chk(gtimes[8] - gtimes[0] == 64, "R5 per-bank period", gtimes[8] - gtimes[0], 64);
    chk(ref_bank == 3'd1, "R6 pointer after wrap", int'(ref_bank), 1);
    per_bank_en = 1'b0;
    step(1);
    chk(ref_bank == 3'd0, "R6 all-bank reads 0", int'(ref_bank), 0);
    chk(ref_per_bank == 1'b0, "R5 all-bank kind", int'(ref_per_bank), 0);

    chk(exp_q.size() == 0, "R8 leftover expected", exp_q.size(), 0);
    finish_run();
  end
endmodule